// File: doc/BRIEF.md
# Register Rename Table with Result-Bus Write-Back

This block keeps the renaming state of an out-of-order core. It holds one row per architectural register, and each row carries a data word, a ready flag and the tag of the most recent instruction that will write that register. When an instruction is renamed, two source lookups return either a finished operand or the tag of the operand's producer. The destination row is then marked pending under a new tag that a separate allocator supplies.

The table also watches the result broadcast bus. A pending row takes a broadcast word only when the broadcast tag equals its own stored tag. A result from an older writer that has since been superseded is therefore dropped. A broadcast that lands in the same cycle as a lookup is passed straight to the lookup output. A release pulse tells the allocator that a tag no longer has any holder in the table.

A rename is taken only while the scheduler reports a free station slot. Lookups always see the table as it stood before the same cycle's rename, so an instruction that reads and writes the same register gets the older producer.

Top module: `rename_table`

## Requirements
- R1: After reset every row is ready, and row i holds the word (17*i + 3) truncated to the data width.
- R2: A lookup of a ready row gives ready=1, that row's stored word and tag output 0.
- R3: An accepted rename makes the destination row pending with the new tag from the next cycle on. A lookup of a pending row with no matching broadcast gives ready=0, word 0 and the stored tag. ren_accept equals ren_valid AND ren_slot_free.
- R4: A broadcast whose tag equals a pending row's tag writes the broadcast word into that row and makes it ready from the next cycle on.
- R5: A broadcast whose tag differs from a pending row's tag leaves that row's flag, tag and word unchanged.
- R6: In a cycle where a looked-up row is pending and the bus carries its tag, the lookup gives ready=1 with the bus word and tag output 0.
- R7: While ren_slot_free is 0, a rename request changes no row and ren_accept is 0.
- R8: If an accepted rename and a matching broadcast address the same row in one cycle, the row ends up pending with the rename's tag.
- R9: tag_release is 1 in exactly those cycles where bus_valid is 1 and some pending row holds bus_tag; release_tag then equals bus_tag.
- R10: Lookups in a cycle with an accepted rename return the row state from before that rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | IDX_W | First source register index |
| rd_a_ready | output | 1 | First source operand available |
| rd_a_value | output | DATA_W | First source word (0 when not ready) |
| rd_a_tag | output | TAG_W | First source producer tag (0 when ready) |
| rd_b_idx | input | IDX_W | Second source register index |
| rd_b_ready | output | 1 | Second source operand available |
| rd_b_value | output | DATA_W | Second source word (0 when not ready) |
| rd_b_tag | output | TAG_W | Second source producer tag (0 when ready) |
| ren_valid | input | 1 | Rename request for a destination |
| ren_slot_free | input | 1 | Scheduler has a free station slot |
| ren_idx | input | IDX_W | Destination register index |
| ren_tag | input | TAG_W | New producer tag for the destination |
| ren_accept | output | 1 | Rename taken this cycle |
| bus_valid | input | 1 | Result broadcast present |
| bus_tag | input | TAG_W | Tag of the broadcast result |
| bus_value | input | DATA_W | Broadcast result word |
| tag_release | output | 1 | Broadcast tag has no holder left |
| release_tag | output | TAG_W | Tag being released |

## Verification
In every cycle the bench sweeps both lookup ports over all eight registers. Each lookup is compared with a table model in the bench, and that comparison separates ready reads, pending reads and same-cycle forwarded reads. Directed sequences cover the cases where a fixed order decides the result. These are a register renamed twice with the older tag then broadcast, which must be ignored, a blocked rename, and a rename colliding with its own row's write-back. A long run of random renames and broadcasts uses a narrow tag range, so tag matches, duplicate tags and release pulses occur often.

// File: rtl/rat_pkg.sv
`timescale 1ns/1ps
package rat_pkg;
  // Word held by a row right after reset.
  function automatic int unsigned reset_word(int unsigned row);
    return row * 17 + 3;
  endfunction

  // A pending row with the same tag as a live broadcast.
  function automatic logic tag_match(logic pending, logic bus_v, logic same_tag);
    return pending && bus_v && same_tag;
  endfunction
endpackage

// File: rtl/rat_row.sv
`timescale 1ns/1ps
module rat_row #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int ROW    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_hit,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_value,
  output logic              row_valid,
  output logic [TAG_W-1:0]  row_tag,
  output logic [DATA_W-1:0] row_value,
  output logic              bus_hit
);
  assign bus_hit = rat_pkg::tag_match(!row_valid, bus_valid, row_tag == bus_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_valid <= 1'b1;
      row_tag   <= '0;
      row_value <= DATA_W'(rat_pkg::reset_word(ROW));
    end else if (ren_hit) begin
      row_valid <= 1'b0;
      row_tag   <= ren_tag;
    end else if (bus_hit) begin
      row_valid <= 1'b1;
      row_value <= bus_value;
    end
  end

  a_r3_rename_pends: assert property (@(posedge clk) disable iff (!rst_n)
    ren_hit |=> (!row_valid && row_tag == $past(ren_tag)));
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hit && !ren_hit) |=> (row_valid && row_value == $past(bus_value)));
  a_r5_stale_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren_hit && !row_valid && bus_valid && bus_tag != row_tag)
      |=> ($stable(row_valid) && $stable(row_tag) && $stable(row_value)));
  a_r8_rename_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_hit && bus_hit) |=> !row_valid);
endmodule

// File: rtl/rat_read_port.sv
`timescale 1ns/1ps
module rat_read_port #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [IDX_W-1:0]                idx,
  input  logic [NUM_REGS-1:0]             valid_vec,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]  tag_vec,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] value_vec,
  input  logic                            bus_valid,
  input  logic [TAG_W-1:0]                bus_tag,
  input  logic [DATA_W-1:0]               bus_value,
  output logic                            ready,
  output logic [DATA_W-1:0]               value,
  output logic [TAG_W-1:0]                tag,
  output logic                            fwd
);
  logic              sel_valid;
  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_value;

  assign sel_valid = valid_vec[idx];
  assign sel_tag   = tag_vec[idx];
  assign sel_value = value_vec[idx];
  assign fwd       = rat_pkg::tag_match(!sel_valid, bus_valid, sel_tag == bus_tag);

  always_comb begin
    ready = sel_valid || fwd;
    tag   = ready ? '0 : sel_tag;
    if (sel_valid)  value = sel_value;
    else if (fwd)   value = bus_value;
    else            value = '0;
  end

  a_r2_ready_read: assert property (@(posedge clk) disable iff (!rst_n)
    valid_vec[idx] |-> (ready && value == value_vec[idx] && tag == '0));
  a_r6_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_vec[idx] && bus_valid && bus_tag == tag_vec[idx]) |-> (ready && value == bus_value));
  a_r3_pending_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_vec[idx] && !(bus_valid && bus_tag == tag_vec[idx]))
      |-> (!ready && tag == tag_vec[idx] && value == '0));
endmodule

// File: rtl/rename_table.sv
`timescale 1ns/1ps
module rename_table #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic              rd_a_ready,
  output logic [DATA_W-1:0] rd_a_value,
  output logic [TAG_W-1:0]  rd_a_tag,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic              rd_b_ready,
  output logic [DATA_W-1:0] rd_b_value,
  output logic [TAG_W-1:0]  rd_b_tag,
  input  logic              ren_valid,
  input  logic              ren_slot_free,
  input  logic [IDX_W-1:0]  ren_idx,
  input  logic [TAG_W-1:0]  ren_tag,
  output logic              ren_accept,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_value,
  output logic              tag_release,
  output logic [TAG_W-1:0]  release_tag
);
  logic [NUM_REGS-1:0]             valid_vec;
  logic [NUM_REGS-1:0][TAG_W-1:0]  tag_vec;
  logic [NUM_REGS-1:0][DATA_W-1:0] value_vec;
  logic [NUM_REGS-1:0]             bus_hit_vec;
  logic [NUM_REGS-1:0]             ren_hit_vec;
  logic                            fwd_a;
  logic                            fwd_b;

  assign ren_accept = ren_valid && ren_slot_free;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    assign ren_hit_vec[r] = ren_accept && (ren_idx == IDX_W'(r));
    rat_row #(.DATA_W(DATA_W), .TAG_W(TAG_W), .ROW(r)) u_row (
      .clk(clk), .rst_n(rst_n),
      .ren_hit(ren_hit_vec[r]), .ren_tag(ren_tag),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
      .row_valid(valid_vec[r]), .row_tag(tag_vec[r]), .row_value(value_vec[r]),
      .bus_hit(bus_hit_vec[r])
    );
  end

  rat_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_rd_a (
    .clk(clk), .rst_n(rst_n), .idx(rd_a_idx),
    .valid_vec(valid_vec), .tag_vec(tag_vec), .value_vec(value_vec),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
    .ready(rd_a_ready), .value(rd_a_value), .tag(rd_a_tag), .fwd(fwd_a)
  );

  rat_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_rd_b (
    .clk(clk), .rst_n(rst_n), .idx(rd_b_idx),
    .valid_vec(valid_vec), .tag_vec(tag_vec), .value_vec(value_vec),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
    .ready(rd_b_ready), .value(rd_b_value), .tag(rd_b_tag), .fwd(fwd_b)
  );

  // No holder of bus_tag remains once the matching rows take the word or are overwritten.
  assign tag_release = |bus_hit_vec;
  assign release_tag = bus_tag;

  a_r7_blocked_rename: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren_slot_free && !bus_valid) |=> ($stable(valid_vec) && $stable(tag_vec) && $stable(value_vec)));
  a_r9_release_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
    tag_release |-> (bus_valid && release_tag == bus_tag));
  a_r6_fwd_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a || fwd_b) |-> tag_release);
  a_r3_single_row_renamed: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ren_hit_vec));
endmodule

// File: tb/tb_rename_table.sv
`timescale 1ns/1ps
module tb_rename_table;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] rd_a_idx = '0, rd_b_idx = '0, ren_idx = '0;
  logic rd_a_ready, rd_b_ready, ren_accept, tag_release;
  logic [DW-1:0] rd_a_value, rd_b_value;
  logic [TW-1:0] rd_a_tag, rd_b_tag, release_tag;
  logic ren_valid = 1'b0, ren_slot_free = 1'b1, bus_valid = 1'b0;
  logic [TW-1:0] ren_tag = '0, bus_tag = '0;
  logic [DW-1:0] bus_value = '0;

  int checks = 0;
  int errors = 0;
  string note = "";
  logic          m_valid [N];
  logic [TW-1:0] m_tag   [N];
  logic [DW-1:0] m_val   [N];

  always #5 clk = ~clk;

  rename_table #(.NUM_REGS(N), .DATA_W(DW), .TAG_W(TW)) dut (.*);

  task automatic chk(string lbl, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", lbl, act, exp);
    end
  endtask

  task automatic chk_port(int r, logic rdy, logic [DW-1:0] v, logic [TW-1:0] t);
    logic fw, er;
    int ev, et;
    string lbl;
    fw = !m_valid[r] && bus_valid && (m_tag[r] == bus_tag);
    er = m_valid[r] || fw;
    ev = m_valid[r] ? int'(m_val[r]) : (fw ? int'(bus_value) : 0);
    et = er ? 0 : int'(m_tag[r]);
    if (note != "") lbl = note;
    else if (ren_valid && ren_slot_free && ren_idx == 3'(r)) lbl = "R10 pre-rename read";
    else if (m_valid[r]) lbl = "R2 ready read";
    else if (fw) lbl = "R6 forward";
    else lbl = "R3 pending read";
    chk($sformatf("%s reg%0d ready", lbl, r), int'(rdy), int'(er));
    chk($sformatf("%s reg%0d value", lbl, r), int'(v), ev);
    chk($sformatf("%s reg%0d tag", lbl, r), int'(t), et);
  endtask

  task automatic sweep();
    logic rel;
    rel = 1'b0;
    for (int r = 0; r < N; r++)
      if (bus_valid && !m_valid[r] && m_tag[r] == bus_tag) rel = 1'b1;
    for (int a = 0; a < N; a++) begin
      rd_a_idx = 3'(a);
      rd_b_idx = 3'(N - 1 - a);
      #0.5;
      chk_port(a, rd_a_ready, rd_a_value, rd_a_tag);
      chk_port(N - 1 - a, rd_b_ready, rd_b_value, rd_b_tag);
    end
    chk("R3/R7 ren_accept", int'(ren_accept), int'(ren_valid && ren_slot_free));
    chk("R9 tag_release", int'(tag_release), int'(rel));
    if (rel) chk("R9 release_tag", int'(release_tag), int'(bus_tag));
  endtask

  task automatic model_update();
    for (int r = 0; r < N; r++) begin
      if (ren_valid && ren_slot_free && ren_idx == 3'(r)) begin
        m_valid[r] = 1'b0;
        m_tag[r]   = ren_tag;
      end else if (bus_valid && !m_valid[r] && m_tag[r] == bus_tag) begin
        m_valid[r] = 1'b1;
        m_val[r]   = bus_value;
      end
    end
  endtask

  task automatic cyc(logic rv, logic rf, int ri, int rt, logic bv, int bt, int bval);
    ren_valid = rv; ren_slot_free = rf; ren_idx = 3'(ri); ren_tag = TW'(rt);
    bus_valid = bv; bus_tag = TW'(bt); bus_value = DW'(bval);
    sweep();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b1, 0, 0, 1'b0, 0, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < N; r++) begin
      m_valid[r] = 1'b1;
      m_tag[r]   = '0;
      m_val[r]   = DW'(r * 17 + 3);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    note = "R1 reset state"; idle();
    note = "R3 rename"; cyc(1, 1, 3, 5, 0, 0, 0);
    note = ""; idle();
    note = "R6 forward"; cyc(0, 1, 0, 0, 1, 5, 16'hBEEF);
    note = "R4 capture"; idle();
    note = ""; cyc(1, 1, 2, 1, 0, 0, 0);
    cyc(1, 1, 2, 2, 0, 0, 0);
    note = "R5 stale bus"; cyc(0, 1, 0, 0, 1, 1, 16'h1111);
    idle();
    note = "R9 release"; cyc(0, 1, 0, 0, 1, 2, 16'h2222);
    note = "R4 capture"; idle();
    note = "R7 blocked"; cyc(1, 0, 4, 7, 0, 0, 0);
    idle();
    note = ""; cyc(1, 1, 6, 3, 0, 0, 0);
    note = "R8 rename wins"; cyc(1, 1, 6, 9, 1, 3, 16'h3333);
    idle();
    note = "R10 self rename"; cyc(1, 1, 6, 10, 0, 0, 0);
    note = "";

    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 3) != 0, ($urandom % 4) != 0, int'($urandom % N), int'($urandom % 4),
          ($urandom % 2) == 0, int'($urandom % 4), int'($urandom % 65536));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule